// File: doc/BRIEF.md
# Two-Way Set-Associative Data Cache with Line Locking

This block sits between a processor word port and a slow memory that moves whole 16-byte lines. Each request address is divided into a tag, a set index and a byte offset. The tag is compared against both ways of the addressed set. A hit finishes in the cycle it is presented. A miss holds the processor off with a low ready signal while the block refills the line. If the line being replaced holds modified data, it is first written back as a whole line.

A mode input chooses between two write policies, and it can be changed while the block is running. In write-through mode, every write reaches memory as a single-word write. In copy-back mode, writes stay in the cache and mark the line dirty. Lock and unlock commands pin a resident line so that the replacement logic never chooses it. When both ways of a set are pinned, a miss to that set is served straight from memory and nothing is allocated.

The processor keeps its request steady until it sees ready high at a rising clock edge. That edge completes the request.

Top module: `lc_cache_top`

## Requirements
- R1: After reset, ready is high when no request is presented and no memory request is raised. Every line is invalid, clean and unlocked, so the first access to any address misses and a line that was locked before reset can be replaced.
- R2: With the default 8 sets, bits [3:0] of the address are the byte offset, bits [3:2] pick the 32-bit word inside the line (word i sits in line bits 32*i+31..32*i), bits [6:4] are the set and bits [31:7] are the tag. Two lines with the same set and different tags can be resident at the same time.
- R3: Operation codes are 0 for read, 1 for write, 2 for lock and 3 for unlock. A read that hits completes in the cycle it is presented, with ready high, the correct word and no memory traffic.
- R4: A read miss holds ready low for the whole stall and issues exactly one line read at the line-aligned address. It installs the line and then completes with the requested word.
- R5: In write-through mode (mode input 1), every write issues one memory write at the line-aligned address. Its word-enable mask has only bit addr[3:2] set and the data sits in that word slot. A hit also updates the cached word. A miss allocates nothing.
- R6: In copy-back mode (mode input 0), a write hit changes only the cache and marks the line dirty. A write miss first fills the line and then merges the word. No memory write happens in either case.
- R7: A dirty line chosen for replacement is written back at its own line address, with all word enables set, before the fill read is issued. A clean victim causes no memory write.
- R8: The victim is an invalid way if there is one. Otherwise it is the least-recently-used way of the set. Recency is updated on every read hit, every write hit and every fill.
- R9: Lock and unlock complete in one cycle. They set or clear the lock bit of the line only when the address hits, and rsp_ok is 1 in that case and 0 otherwise.
- R10: A locked line is never replaced. If the LRU way is locked, the other way is used. If both ways are locked, a read miss is served by one memory line read without allocation, and a copy-back write miss goes to memory as a word write.
- R11: A memory request stays raised, with a stable address, until mem_ack, and each acknowledge ends exactly one transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wt_mode | input | 1 | 1 = write-through, 0 = copy-back |
| req_valid | input | 1 | Processor request present |
| req_op | input | 2 | 0 read, 1 write, 2 lock, 3 unlock |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | WORD_W | Write data |
| rsp_ready | output | 1 | Request completes at this edge; low during any stall |
| rsp_rdata | output | WORD_W | Read data |
| rsp_ok | output | 1 | Lock or unlock succeeded |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = memory write, 0 = line read |
| mem_addr | output | ADDR_W | Line-aligned memory address |
| mem_wdata | output | LINE_W | Line write data |
| mem_word_en | output | WORDS | Per-word write enables |
| mem_ack | input | 1 | Memory completes the transaction |
| mem_rdata | input | LINE_W | Line read data, valid with mem_ack |

## Verification
Most internal faults stay hidden until the next access to the same set, and then show up as counted memory traffic. A dirty bit that is set wrongly or lost appears as an extra or a missing full-line write at the next replacement in that set. A wrong recency bit or lock bit appears as an extra miss, or as a pinned line missing, on the following read. A bad merge or a bad word select shows up in the very next read of that word. The bench therefore counts memory reads and writes per access, checks their addresses, masks and order, and compares memory contents after each eviction.

// File: rtl/lc_pkg.sv
`timescale 1ns/1ps
package lc_pkg;
   typedef enum logic [1:0] {
      OP_READ   = 2'd0,
      OP_WRITE  = 2'd1,
      OP_LOCK   = 2'd2,
      OP_UNLOCK = 2'd3
   } op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_EVICT,
      ST_FILL,
      ST_MWRITE,
      ST_MREAD,
      ST_DONE
   } st_e;
endpackage

// File: rtl/lc_way_store.sv
`timescale 1ns/1ps
module lc_way_store #(
   parameter int SETS   = 8,
   parameter int TAG_W  = 25,
   parameter int LINE_W = 128,
   parameter int WORD_W = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [$clog2(SETS)-1:0]    set_idx,
   input  logic                       fill_we,
   input  logic [TAG_W-1:0]           fill_tag,
   input  logic [LINE_W-1:0]          fill_line,
   input  logic                       word_we,
   input  logic [$clog2(LINE_W/WORD_W)-1:0] word_sel,
   input  logic [WORD_W-1:0]          word_data,
   input  logic                       mark_dirty,
   input  logic                       lock_we,
   input  logic                       lock_val,
   output logic                       valid_o,
   output logic                       dirty_o,
   output logic                       lock_o,
   output logic [TAG_W-1:0]           tag_o,
   output logic [LINE_W-1:0]          line_o
);
   logic [SETS-1:0]   valid_q;
   logic [SETS-1:0]   dirty_q;
   logic [SETS-1:0]   lock_q;
   logic [TAG_W-1:0]  tag_q  [SETS];
   logic [LINE_W-1:0] line_q [SETS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
         lock_q  <= '0;
         for (int s = 0; s < SETS; s++) begin
            tag_q[s]  <= '0;
            line_q[s] <= '0;
         end
      end else if (fill_we) begin
         valid_q[set_idx] <= 1'b1;
         dirty_q[set_idx] <= 1'b0;
         lock_q[set_idx]  <= 1'b0;
         tag_q[set_idx]   <= fill_tag;
         line_q[set_idx]  <= fill_line;
      end else begin
         if (word_we) begin
            line_q[set_idx][word_sel*WORD_W +: WORD_W] <= word_data;
            if (mark_dirty) dirty_q[set_idx] <= 1'b1;
         end
         if (lock_we) lock_q[set_idx] <= lock_val;
      end
   end

   assign valid_o = valid_q[set_idx];
   assign dirty_o = dirty_q[set_idx];
   assign lock_o  = lock_q[set_idx];
   assign tag_o   = tag_q[set_idx];
   assign line_o  = line_q[set_idx];
endmodule

// File: rtl/lc_lru.sv
`timescale 1ns/1ps
module lc_lru #(
   parameter int SETS = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [$clog2(SETS)-1:0] set_idx,
   input  logic                    upd_en,
   input  logic                    used_way,
   output logic                    lru_way
);
   logic [SETS-1:0] old_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      old_q <= '0;
      else if (upd_en) old_q[set_idx] <= ~used_way;
   end

   assign lru_way = old_q[set_idx];
endmodule

// File: rtl/lc_victim.sv
`timescale 1ns/1ps
module lc_victim (
   input  logic [1:0] valid,
   input  logic [1:0] locked,
   input  logic       lru_way,
   output logic       vic_way,
   output logic       vic_ok
);
   always_comb begin
      vic_ok  = 1'b1;
      vic_way = lru_way;
      if (!valid[0])              vic_way = 1'b0;
      else if (!valid[1])         vic_way = 1'b1;
      else if (!locked[lru_way])  vic_way = lru_way;
      else if (!locked[~lru_way]) vic_way = ~lru_way;
      else                        vic_ok  = 1'b0;
   end
endmodule

// File: rtl/lc_cache_top.sv
`timescale 1ns/1ps
module lc_cache_top #(
   parameter int ADDR_W     = 32,
   parameter int WORD_W     = 32,
   parameter int LINE_BYTES = 16,
   parameter int SETS       = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wt_mode,
   input  logic                          req_valid,
   input  logic [1:0]                    req_op,
   input  logic [ADDR_W-1:0]             req_addr,
   input  logic [WORD_W-1:0]             req_wdata,
   output logic                          rsp_ready,
   output logic [WORD_W-1:0]             rsp_rdata,
   output logic                          rsp_ok,
   output logic                          mem_req,
   output logic                          mem_we,
   output logic [ADDR_W-1:0]             mem_addr,
   output logic [LINE_BYTES*8-1:0]       mem_wdata,
   output logic [LINE_BYTES*8/WORD_W-1:0] mem_word_en,
   input  logic                          mem_ack,
   input  logic [LINE_BYTES*8-1:0]       mem_rdata
);
   import lc_pkg::*;

   localparam int LINE_W = LINE_BYTES * 8;
   localparam int WORDS  = LINE_W / WORD_W;
   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int SET_W  = $clog2(SETS);
   localparam int TAG_W  = ADDR_W - OFF_W - SET_W;
   localparam int WSEL_W = $clog2(WORDS);
   localparam int BOFF_W = $clog2(WORD_W / 8);
   localparam int NWAYS  = 2;

   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if ((LINE_W % WORD_W) != 0 || WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_line
      $error("line must hold a power-of-two count of at least two words");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("address too narrow for offset and set fields");
   end

   st_e st_q, st_d;
   logic vic_q;
   logic [LINE_W-1:0] buf_q;

   logic [SET_W-1:0]  set_idx;
   logic [TAG_W-1:0]  req_tag;
   logic [WSEL_W-1:0] wsel;
   logic              unused_boff;

   assign set_idx     = req_addr[OFF_W +: SET_W];
   assign req_tag     = req_addr[ADDR_W-1 -: TAG_W];
   assign wsel        = req_addr[BOFF_W +: WSEL_W];
   assign unused_boff = ^req_addr[BOFF_W-1:0];

   logic op_rd, op_wr, op_lk, op_ul;
   assign op_rd = (req_op == OP_READ);
   assign op_wr = (req_op == OP_WRITE);
   assign op_lk = (req_op == OP_LOCK);
   assign op_ul = (req_op == OP_UNLOCK);

   logic [NWAYS-1:0]  w_valid, w_dirty, w_lock, hit_vec;
   logic [NWAYS-1:0]  fill_we, word_we, lock_we;
   logic [TAG_W-1:0]  w_tag  [NWAYS];
   logic [LINE_W-1:0] w_line [NWAYS];
   logic              mark_dirty;

   for (genvar w = 0; w < NWAYS; w++) begin : g_way
      lc_way_store #(
         .SETS(SETS), .TAG_W(TAG_W), .LINE_W(LINE_W), .WORD_W(WORD_W)
      ) u_store (
         .clk        (clk),
         .rst_n      (rst_n),
         .set_idx    (set_idx),
         .fill_we    (fill_we[w]),
         .fill_tag   (req_tag),
         .fill_line  (mem_rdata),
         .word_we    (word_we[w]),
         .word_sel   (wsel),
         .word_data  (req_wdata),
         .mark_dirty (mark_dirty),
         .lock_we    (lock_we[w]),
         .lock_val   (op_lk),
         .valid_o    (w_valid[w]),
         .dirty_o    (w_dirty[w]),
         .lock_o     (w_lock[w]),
         .tag_o      (w_tag[w]),
         .line_o     (w_line[w])
      );
      assign hit_vec[w] = w_valid[w] && (w_tag[w] == req_tag);
   end

   logic hit, hit_way;
   assign hit     = |hit_vec;
   assign hit_way = hit_vec[1];

   logic lru_way, vic_way, vic_ok, vic_dirty;
   lc_victim u_vic (
      .valid   (w_valid),
      .locked  (w_lock),
      .lru_way (lru_way),
      .vic_way (vic_way),
      .vic_ok  (vic_ok)
   );
   assign vic_dirty = w_valid[vic_way] && w_dirty[vic_way];

   logic in_idle, in_done, fill_done, acc_hit_upd, lru_upd, lru_used;
   assign in_idle   = (st_q == ST_IDLE);
   assign in_done   = (st_q == ST_DONE);
   assign fill_done = (st_q == ST_FILL) && mem_ack;

   assign acc_hit_upd = req_valid && hit &&
                        ((in_idle && (op_rd || (op_wr && !wt_mode))) || (in_done && op_wr));
   assign lru_upd     = fill_done || acc_hit_upd;
   assign lru_used    = fill_done ? vic_q : hit_way;

   lc_lru #(.SETS(SETS)) u_lru (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_idx  (set_idx),
      .upd_en   (lru_upd),
      .used_way (lru_used),
      .lru_way  (lru_way)
   );

   assign mark_dirty = in_idle;
   for (genvar w = 0; w < NWAYS; w++) begin : g_ctl
      assign fill_we[w] = fill_done && (vic_q == 1'(w));
      assign word_we[w] = req_valid && op_wr && hit_vec[w] &&
                          ((in_idle && !wt_mode) || in_done);
      assign lock_we[w] = in_idle && req_valid && (op_lk || op_ul) && hit_vec[w];
   end

   // next state
   logic latch_vic;
   always_comb begin
      st_d      = st_q;
      latch_vic = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (req_valid) begin
               if (op_rd && !hit) begin
                  if (vic_ok) begin
                     st_d      = vic_dirty ? ST_EVICT : ST_FILL;
                     latch_vic = 1'b1;
                  end else begin
                     st_d = ST_MREAD;
                  end
               end else if (op_wr && wt_mode) begin
                  st_d = ST_MWRITE;
               end else if (op_wr && !hit) begin
                  if (vic_ok) begin
                     st_d      = vic_dirty ? ST_EVICT : ST_FILL;
                     latch_vic = 1'b1;
                  end else begin
                     st_d = ST_MWRITE;
                  end
               end
            end
         end
         ST_EVICT:  if (mem_ack) st_d = ST_FILL;
         ST_FILL:   if (mem_ack) st_d = ST_IDLE;
         ST_MWRITE: if (mem_ack) st_d = ST_DONE;
         ST_MREAD:  if (mem_ack) st_d = ST_DONE;
         ST_DONE:   st_d = ST_IDLE;
         default:   st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         vic_q <= 1'b0;
         buf_q <= '0;
      end else begin
         st_q <= st_d;
         if (latch_vic) vic_q <= vic_way;
         if (st_q == ST_MREAD && mem_ack) buf_q <= mem_rdata;
      end
   end

   // processor response
   logic done_now;
   assign done_now = op_lk || op_ul || (op_rd && hit) || (op_wr && !wt_mode && hit);

   always_comb begin
      unique case (st_q)
         ST_IDLE: rsp_ready = !req_valid || done_now;
         ST_DONE: rsp_ready = 1'b1;
         default: rsp_ready = 1'b0;
      endcase
   end

   assign rsp_rdata = in_done ? buf_q[wsel*WORD_W +: WORD_W]
                              : w_line[hit_way][wsel*WORD_W +: WORD_W];
   assign rsp_ok    = in_idle && req_valid && (op_lk || op_ul) && hit;

   // memory port
   logic [WORDS-1:0] word_onehot;
   always_comb begin
      word_onehot       = '0;
      word_onehot[wsel] = 1'b1;
   end

   assign mem_req     = (st_q == ST_EVICT) || (st_q == ST_FILL) ||
                        (st_q == ST_MWRITE) || (st_q == ST_MREAD);
   assign mem_we      = (st_q == ST_EVICT) || (st_q == ST_MWRITE);
   assign mem_addr    = (st_q == ST_EVICT) ? {w_tag[vic_q], set_idx, {OFF_W{1'b0}}}
                                           : {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
   assign mem_wdata   = (st_q == ST_EVICT) ? w_line[vic_q] : {WORDS{req_wdata}};
   assign mem_word_en = (st_q == ST_MWRITE) ? word_onehot : {WORDS{1'b1}};
endmodule

// File: rtl/lc_cache_chk.sv
`timescale 1ns/1ps
module lc_cache_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wt_mode,
   input logic              rsp_ready,
   input logic              rsp_ok,
   input logic              mem_req,
   input logic              mem_ack,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [1:0]        hit_vec,
   input logic [1:0]        fill_we,
   input logic [1:0]        word_we,
   input logic [1:0]        w_lock,
   input logic              mark_dirty
);
   // R4: the processor never sees ready while memory is busy
   assert_stall_not_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !rsp_ready);

   // R11: request held with a steady address until acknowledged
   assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

   // R10: a fill never lands on a locked way
   assert_no_fill_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (|fill_we) |-> ((fill_we & w_lock) == 2'b00));

   // R2: a tag is resident in at most one way of a set
   assert_single_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   // R6: dirty marking only happens in copy-back mode
   assert_dirty_cb_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((|word_we) && mark_dirty) |-> !wt_mode);

   // R9: lock success is reported only on a completing cycle
   assert_ok_with_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ok |-> rsp_ready);
endmodule

bind lc_cache_top lc_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wt_mode    (wt_mode),
   .rsp_ready  (rsp_ready),
   .rsp_ok     (rsp_ok),
   .mem_req    (mem_req),
   .mem_ack    (mem_ack),
   .mem_addr   (mem_addr),
   .hit_vec    (hit_vec),
   .fill_we    (fill_we),
   .word_we    (word_we),
   .w_lock     (w_lock),
   .mark_dirty (mark_dirty)
);

// File: tb/sim_lc_cache_top.sv
`timescale 1ns/1ps
module sim_lc_cache_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wt_mode = 1'b0;
   logic         req_valid = 1'b0;
   logic [1:0]   req_op = 2'd0;
   logic [31:0]  req_addr = '0;
   logic [31:0]  req_wdata = '0;
   logic         rsp_ready, rsp_ok;
   logic [31:0]  rsp_rdata;
   logic         mem_req, mem_we;
   logic [31:0]  mem_addr;
   logic [127:0] mem_wdata;
   logic [3:0]   mem_word_en;
   logic         mem_ack = 1'b0;
   logic [127:0] mem_rdata = '0;

   always #2.5 clk = ~clk;

   lc_cache_top u0 (
      .clk(clk), .rst_n(rst_n), .wt_mode(wt_mode),
      .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_ok(rsp_ok),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_word_en(mem_word_en), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   // memory model: 1 KB, three-cycle latency
   logic [31:0] mem_w  [256];
   logic [31:0] shadow [256];
   int          n_rd = 0, n_wr = 0, lat = 0;
   longint      cyc = 0, rd_cyc = 0, wr_cyc = 0;
   logic [31:0] last_rd_addr = '0, last_wr_addr = '0;
   logic [3:0]  last_wr_en = '0;

   initial begin
      for (int i = 0; i < 256; i++) begin
         mem_w[i]  = 32'hC0DE_0000 | (i * 4);
         shadow[i] = 32'hC0DE_0000 | (i * 4);
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) begin
         lat     <= 0;
         mem_ack <= 1'b0;
      end else begin
         mem_ack <= 1'b0;
         if (mem_req && !mem_ack) begin
            if (lat == 2) begin
               lat     <= 0;
               mem_ack <= 1'b1;
               if (mem_we) begin
                  for (int j = 0; j < 4; j++)
                     if (mem_word_en[j]) mem_w[mem_addr[9:4]*4 + j] <= mem_wdata[j*32 +: 32];
                  n_wr         <= n_wr + 1;
                  last_wr_addr <= mem_addr;
                  last_wr_en   <= mem_word_en;
                  wr_cyc       <= cyc;
               end else begin
                  for (int j = 0; j < 4; j++)
                     mem_rdata[j*32 +: 32] <= mem_w[mem_addr[9:4]*4 + j];
                  n_rd         <= n_rd + 1;
                  last_rd_addr <= mem_addr;
                  rd_cyc       <= cyc;
               end
            end else begin
               lat <= lat + 1;
            end
         end
      end
   end

   int n_chk = 0, n_bad = 0;

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   logic [31:0] r_data;
   logic        r_ok;
   int          r_stall, d_rd, d_wr;

   task automatic xfer(input logic [1:0] op, input logic [31:0] addr, input logic [31:0] wd);
      int rd0, wr0;
      rd0 = n_rd;
      wr0 = n_wr;
      @(negedge clk);
      req_op = op; req_addr = addr; req_wdata = wd; req_valid = 1'b1;
      r_stall = 0;
      #1;
      while (!rsp_ready) begin
         r_stall++;
         @(negedge clk);
         #1;
      end
      r_data = rsp_rdata;
      r_ok   = rsp_ok;
      @(posedge clk);
      #1 req_valid = 1'b0;
      if (op == 2'd1) shadow[addr[9:2]] = wd;
      d_rd = n_rd - rd0;
      d_wr = n_wr - wr0;
   endtask

   task automatic rd_chk(input logic [31:0] addr, input int exp_rd, input int exp_wr, input string tag);
      xfer(2'd0, addr, 32'h0);
      chk({tag, " data"}, r_data, shadow[addr[9:2]]);
      chk({tag, " line reads"}, d_rd, exp_rd);
      chk({tag, " line writes"}, d_wr, exp_wr);
      if (exp_rd == 0 && exp_wr == 0) chk({tag, " stall"}, r_stall, 0);
   endtask

   task automatic do_reset;
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset;
      do_reset();
      #1;
      chk("R1 ready after reset", rsp_ready, 1);
      chk("R1 no mem request", mem_req, 0);
   endtask

   task automatic t_miss_hit;
      rd_chk(32'h004, 1, 0, "R1 R4 first read misses");
      chk("R4 stall seen", r_stall > 0, 1);
      chk("R4 line aligned", last_rd_addr, 32'h000);
      rd_chk(32'h008, 0, 0, "R3 read hit");
   endtask

   task automatic t_two_way;
      rd_chk(32'h100, 1, 0, "R2 second tag same set");
      rd_chk(32'h00C, 0, 0, "R2 first line still resident");
      rd_chk(32'h104, 0, 0, "R2 second line resident");
   endtask

   task automatic t_lru;
      rd_chk(32'h200, 1, 0, "R8 miss replaces lru");
      rd_chk(32'h108, 0, 0, "R8 recent line kept");
      rd_chk(32'h000, 1, 0, "R8 lru line was evicted");
   endtask

   task automatic t_copyback;
      wt_mode = 1'b0;
      xfer(2'd1, 32'h024, 32'hDEAD_BEEF);
      chk("R6 write miss allocates", d_rd, 1);
      chk("R6 no mem write", d_wr, 0);
      chk("R6 memory untouched", mem_w[32'h024 >> 2], 32'hC0DE_0024);
      rd_chk(32'h024, 0, 0, "R6 merged word");
      rd_chk(32'h0A0, 1, 0, "R6 fill other way");
      rd_chk(32'h120, 1, 1, "R7 dirty eviction");
      chk("R7 writeback addr", last_wr_addr, 32'h020);
      chk("R7 full line enables", last_wr_en, 4'hF);
      chk("R7 writeback data", mem_w[32'h024 >> 2], 32'hDEAD_BEEF);
      chk("R7 write before fill", wr_cyc < rd_cyc, 1);
      rd_chk(32'h0A4, 0, 0, "R8 hit updates recency");
      rd_chk(32'h1A0, 1, 0, "R7 clean victim no write");
   endtask

   task automatic t_writethru;
      wt_mode = 1'b1;
      rd_chk(32'h030, 1, 0, "R5 prime line");
      xfer(2'd1, 32'h034, 32'h1111_2222);
      chk("R5 hit write to memory", d_wr, 1);
      chk("R5 no read", d_rd, 0);
      chk("R5 stalled", r_stall > 0, 1);
      chk("R5 address", last_wr_addr, 32'h030);
      chk("R5 word enable", last_wr_en, 4'b0010);
      chk("R5 memory word", mem_w[32'h034 >> 2], 32'h1111_2222);
      rd_chk(32'h034, 0, 0, "R5 cache updated");
      xfer(2'd1, 32'h0B8, 32'h3333_4444);
      chk("R5 miss write", d_wr, 1);
      chk("R5 miss no fill", d_rd, 0);
      chk("R5 miss enable", last_wr_en, 4'b0100);
      rd_chk(32'h0B8, 1, 0, "R5 miss did not allocate");
      wt_mode = 1'b0;
   endtask

   task automatic t_lock;
      rd_chk(32'h040, 1, 0, "R9 prime");
      xfer(2'd2, 32'h040, 0);
      chk("R9 lock hit ok", r_ok, 1);
      chk("R9 lock one cycle", r_stall, 0);
      xfer(2'd2, 32'h0C0, 0);
      chk("R9 lock miss not ok", r_ok, 0);
      chk("R9 lock miss no traffic", d_rd + d_wr, 0);
      rd_chk(32'h0C0, 1, 0, "R9 lock miss left line absent");
      rd_chk(32'h140, 1, 0, "R10 lru locked uses other way");
      rd_chk(32'h044, 0, 0, "R10 locked line stays");
      xfer(2'd2, 32'h140, 0);
      chk("R9 second lock ok", r_ok, 1);
      rd_chk(32'h1C0, 1, 0, "R10 both locked bypass");
      rd_chk(32'h1C4, 1, 0, "R10 bypass not allocated");
      rd_chk(32'h148, 0, 0, "R10 locked pair intact");
      xfer(2'd1, 32'h2C4, 32'h5555_6666);
      chk("R10 locked write to memory", d_wr, 1);
      chk("R10 locked write no fill", d_rd, 0);
      chk("R10 locked write data", mem_w[32'h2C4 >> 2], 32'h5555_6666);
      xfer(2'd3, 32'h0C0, 0);
      chk("R9 unlock miss not ok", r_ok, 0);
      xfer(2'd3, 32'h040, 0);
      chk("R9 unlock ok", r_ok, 1);
      rd_chk(32'h1C0, 1, 0, "R9 unlocked way refilled");
      rd_chk(32'h1C8, 0, 0, "R9 refill resident");
      rd_chk(32'h044, 1, 0, "R9 unlocked line gone");
   endtask

   task automatic t_reset_clear;
      xfer(2'd2, 32'h044, 0);
      chk("R9 relock ok", r_ok, 1);
      do_reset();
      rd_chk(32'h148, 1, 0, "R1 valid cleared");
      rd_chk(32'h044, 1, 0, "R1 refill second way");
      rd_chk(32'h2C0, 1, 0, "R1 locks cleared replace");
      rd_chk(32'h2C4, 0, 0, "R1 new line resident");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_miss_hit();
      t_two_way();
      t_lru();
      t_copyback();
      t_writethru();
      t_lock();
      t_reset_clear();
      repeat (4) @(negedge clk);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule